// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block runs next to a DRAM access sequencer and owns everything the memory needs to keep its contents. After reset it waits out the power-on pause. It then runs a burst of wake-up cycles. Once those are done it raises `init_done` and starts issuing one distributed refresh per interval. The interval is derived from the clock rate, the retention period and the row count. Every refresh is a column-before-row cycle: the column strobes drop first, the row strobe follows, and the address and data pins are left alone.

The scheduler never drives the control bus on its own authority. It raises `ref_req` and waits for the access sequencer to return `bus_grant` from its idle state. It then plays its strobe sequence with `own_bus` high and releases the bus when precharge is over. A pending counter absorbs refreshes that the access side postpones. `ref_urgent` tells the access side when the backlog is deep. If the backlog grows so far that retention can no longer be assumed, the block withdraws `init_done` and repeats the whole wake-up burst.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is high and on the first cycle after it, `ras_n`=1, every `cas_n` bit=1, and `own_bus`, `ref_req`, `ref_urgent` and `init_done` are all 0.
- R2: After reset is released, `ref_req` stays low for at least PAUSE_US microseconds of clock, which is CLK_KHZ*PAUSE_US/1000 cycles.
- R3: `init_done` stays 0 until WAKE_CYCLES refresh cycles (default 8) have completed, and rises right after the last of them.
- R4: In every refresh cycle, all `cas_n` bits fall together. They are low for CSR_CYC cycles before `ras_n` falls and stay low for CHR_CYC cycles after it. `ras_n` is low for RAS_CYC cycles. `ras_n` then stays high for RP_CYC cycles while `own_bus` is still 1.
- R5: `ras_n` and `cas_n` stay high whenever `own_bus` is 0. `own_bus` rises only after `ref_req` and `bus_grant` were both high. `ref_req` stays high from the request until the granted cycle finishes.
- R6: Once initialised, with the bus granted promptly, the block issues one refresh per CLK_KHZ*RETENTION_MS/ROWS cycles.
- R7: The pending count rises at every interval tick and falls at every completed refresh. `ref_urgent` is high exactly while the count is at least URGENT_LEVEL.
- R8: When the pending count reaches LOST_LEVEL, `init_done` falls and the count is cleared, so `ref_urgent` is 0. Exactly WAKE_CYCLES further refresh cycles are then needed before `init_done` returns.
- R9: While the pending count is nonzero, the next request follows the end of a refresh within two cycles. With an immediate grant, the bus is idle for at most four sampled cycles between cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_grant | input | 1 | Access sequencer hands the shared control bus over |
| ref_req | output | 1 | Refresh or wake-up cycle wanted; held until that cycle ends |
| ref_urgent | output | 1 | Backlog at or above the urgency threshold |
| own_bus | output | 1 | Scheduler is driving the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | CAS_LINES | Column strobes, active low, driven together |
| init_done | output | 1 | Power-up sequence complete; normal access allowed |

## Verification
The bench builds the block with CLK_KHZ=100 and ROWS=32. The pause is then 20 cycles and the refresh interval 50 cycles, with URGENT_LEVEL=3 and LOST_LEVEL=6. Strobe widths are CSR=2, CHR=3, RAS=5 and RP=4. These values bring the wake-up burst, a deep backlog with its urgency flag, and the retention-loss restart within a few hundred cycles each. A table of grant latencies drives the eight wake-up cycles. A monitor measures the strobe shape of every cycle the block runs.

// File: rtl/dref_pkg.sv
package dref_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_CSR,
    SQ_ROW,
    SQ_PRE
  } seq_state_t;

  typedef enum logic [1:0] {
    TP_PAUSE,
    TP_IDLE,
    TP_REQ,
    TP_RUN
  } top_state_t;

endpackage

// File: rtl/dref_timer.sv
module dref_timer #(
  parameter int PAUSE_CYC    = 20000,
  parameter int INTERVAL_CYC = 1562
) (
  input  logic clk,
  input  logic rst,
  input  logic run_en,
  output logic pause_done,
  output logic tick
);
  localparam int PW = $clog2(PAUSE_CYC + 1);
  localparam int IW = $clog2(INTERVAL_CYC + 1);

  logic [PW-1:0] pcnt;
  logic [IW-1:0] icnt;

  // power-on pause, counted once after reset
  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt       <= '0;
      pause_done <= 1'b0;
    end else if (!pause_done) begin
      if (pcnt == PW'(PAUSE_CYC - 1)) pause_done <= 1'b1;
      else                            pcnt       <= pcnt + 1'b1;
    end
  end

  // distributed refresh interval, only while initialised
  always_ff @(posedge clk) begin
    if (rst || !run_en) begin
      icnt <= '0;
      tick <= 1'b0;
    end else if (icnt == IW'(INTERVAL_CYC - 1)) begin
      icnt <= '0;
      tick <= 1'b1;
    end else begin
      icnt <= icnt + 1'b1;
      tick <= 1'b0;
    end
  end

  assert_tick_gated_R6: assert property (@(posedge clk) disable iff (rst)
    tick |-> $past(run_en));

  assert_pause_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    $past(pause_done) |-> pause_done);

endmodule

// File: rtl/dref_backlog.sv
module dref_backlog #(
  parameter int URGENT_LEVEL = 8,
  parameter int LOST_LEVEL   = 32,
  parameter int PEND_W       = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              served,
  input  logic              clear,
  output logic [PEND_W-1:0] pend,
  output logic              urgent,
  output logic              lost
);
  logic [PEND_W-1:0] pend_nxt;

  always_comb begin
    pend_nxt = pend;
    if (clear)                                pend_nxt = '0;
    else if (tick && !served)                 pend_nxt = pend + 1'b1;
    else if (!tick && served && pend != '0)   pend_nxt = pend - 1'b1;
  end

  // flags are registered from the next count so they line up with pend
  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= '0;
      urgent <= 1'b0;
      lost   <= 1'b0;
    end else begin
      pend   <= pend_nxt;
      urgent <= (pend_nxt >= PEND_W'(URGENT_LEVEL));
      lost   <= (pend_nxt >= PEND_W'(LOST_LEVEL));
    end
  end

  assert_urgent_level_R7: assert property (@(posedge clk) disable iff (rst)
    urgent == (pend >= PEND_W'(URGENT_LEVEL)));

  assert_single_step_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(clear) |-> (pend == $past(pend) || pend == $past(pend) + 1'b1 ||
                       pend == $past(pend) - 1'b1));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    pend <= PEND_W'(LOST_LEVEL));

endmodule

// File: rtl/dref_cbr_seq.sv
module dref_cbr_seq
  import dref_pkg::*;
#(
  parameter int CAS_LINES = 2,
  parameter int CSR_CYC   = 2,
  parameter int CHR_CYC   = 3,
  parameter int RAS_CYC   = 6,
  parameter int RP_CYC    = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  output logic                 ras_n,
  output logic [CAS_LINES-1:0] cas_n,
  output logic                 bus_own,
  output logic                 done
);
  localparam int M1 = (CSR_CYC > RAS_CYC) ? CSR_CYC : RAS_CYC;
  localparam int M2 = (RP_CYC > M1) ? RP_CYC : M1;
  localparam int CW = $clog2(M2 + 1);

  seq_state_t    st;
  logic [CW-1:0] el;
  logic          ras_q;
  logic          cas_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SQ_IDLE;
      el      <= '0;
      ras_q   <= 1'b1;
      cas_q   <= 1'b1;
      bus_own <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        SQ_IDLE: if (start) begin
          st      <= SQ_CSR;
          el      <= '0;
          cas_q   <= 1'b0;
          bus_own <= 1'b1;
        end
        SQ_CSR: if (el == CW'(CSR_CYC - 1)) begin
          st    <= SQ_ROW;
          el    <= '0;
          ras_q <= 1'b0;
        end else el <= el + 1'b1;
        SQ_ROW: begin
          if (el == CW'(CHR_CYC - 1)) cas_q <= 1'b1;
          if (el == CW'(RAS_CYC - 1)) begin
            st    <= SQ_PRE;
            el    <= '0;
            ras_q <= 1'b1;
            cas_q <= 1'b1;
          end else el <= el + 1'b1;
        end
        SQ_PRE: if (el == CW'(RP_CYC - 1)) begin
          st      <= SQ_IDLE;
          el      <= '0;
          bus_own <= 1'b0;
          done    <= 1'b1;
        end else el <= el + 1'b1;
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign ras_n = ras_q;
  for (genvar g = 0; g < CAS_LINES; g++) begin : g_cas
    assign cas_n[g] = cas_q;
  end

  assert_cas_first_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_q) |-> (!cas_q && $past(!cas_q)));

  assert_quiet_unowned_R5: assert property (@(posedge clk) disable iff (rst)
    !bus_own |-> (ras_q && cas_q));

  assert_done_releases_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> (!bus_own && $past(bus_own) && $past(ras_q)));

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dref_pkg::*;
#(
  parameter int CLK_KHZ      = 100000,
  parameter int PAUSE_US     = 200,
  parameter int RETENTION_MS = 16,
  parameter int ROWS         = 1024,
  parameter int WAKE_CYCLES  = 8,
  parameter int CAS_LINES    = 2,
  parameter int CSR_CYC      = 2,
  parameter int CHR_CYC      = 3,
  parameter int RAS_CYC      = 6,
  parameter int RP_CYC       = 4,
  parameter int URGENT_LEVEL = 8,
  parameter int LOST_LEVEL   = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_grant,
  output logic                 ref_req,
  output logic                 ref_urgent,
  output logic                 own_bus,
  output logic                 ras_n,
  output logic [CAS_LINES-1:0] cas_n,
  output logic                 init_done
);
  localparam int PAUSE_CYC    = CLK_KHZ * PAUSE_US / 1000;
  localparam int INTERVAL_CYC = CLK_KHZ * RETENTION_MS / ROWS;
  localparam int PEND_W       = $clog2(LOST_LEVEL + 1);
  localparam int WW           = $clog2(WAKE_CYCLES + 1);

  top_state_t        st;
  logic [WW-1:0]     wake;
  logic              init_q;
  logic              req_q;
  logic              pause_done;
  logic              tick;
  logic              seq_start;
  logic              seq_done;
  logic              served;
  logic              lost;
  logic [PEND_W-1:0] pend;

  assign seq_start = (st == TP_REQ) && bus_grant;
  assign served    = seq_done && init_q;

  dref_timer #(
    .PAUSE_CYC   (PAUSE_CYC),
    .INTERVAL_CYC(INTERVAL_CYC)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .run_en    (init_q),
    .pause_done(pause_done),
    .tick      (tick)
  );

  dref_backlog #(
    .URGENT_LEVEL(URGENT_LEVEL),
    .LOST_LEVEL  (LOST_LEVEL),
    .PEND_W      (PEND_W)
  ) u_backlog (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick && init_q),
    .served(served),
    .clear (lost),
    .pend  (pend),
    .urgent(ref_urgent),
    .lost  (lost)
  );

  dref_cbr_seq #(
    .CAS_LINES(CAS_LINES),
    .CSR_CYC  (CSR_CYC),
    .CHR_CYC  (CHR_CYC),
    .RAS_CYC  (RAS_CYC),
    .RP_CYC   (RP_CYC)
  ) u_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (seq_start),
    .ras_n  (ras_n),
    .cas_n  (cas_n),
    .bus_own(own_bus),
    .done   (seq_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= TP_PAUSE;
      wake   <= '0;
      init_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      case (st)
        TP_PAUSE: if (pause_done) begin
          st    <= TP_REQ;
          req_q <= 1'b1;
        end
        TP_IDLE: if (!init_q || pend != '0) begin
          st    <= TP_REQ;
          req_q <= 1'b1;
        end
        TP_REQ: if (bus_grant) st <= TP_RUN;
        TP_RUN: if (seq_done) begin
          st    <= TP_IDLE;
          req_q <= 1'b0;
          if (!init_q) begin
            if (wake == WW'(WAKE_CYCLES - 1)) begin
              init_q <= 1'b1;
              wake   <= '0;
            end else wake <= wake + 1'b1;
          end
        end
        default: st <= TP_IDLE;
      endcase
      // retention no longer guaranteed: rerun the wake-up burst
      if (lost) begin
        init_q <= 1'b0;
        wake   <= '0;
      end
    end
  end

  assign ref_req   = req_q;
  assign init_done = init_q;

  assert_strobe_owned_R5: assert property (@(posedge clk) disable iff (rst)
    (!ras_n || cas_n != '1) |-> own_bus);

  assert_grant_before_own_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(own_bus) |-> ($past(ref_req) && $past(bus_grant)));

  assert_req_until_done_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(ref_req) |-> $past(seq_done));

  assert_init_after_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(init_done) |-> $past(seq_done));

  assert_urgent_needs_init_R8: assert property (@(posedge clk) disable iff (rst)
    ref_urgent |-> init_done);

endmodule

// File: tb/dram_refresh_sched_bench.sv
module dram_refresh_sched_bench;
  localparam int CLK_KHZ = 100;
  localparam int PAUSE_US = 200;
  localparam int RET_MS = 16;
  localparam int ROWS = 32;
  localparam int WAKE = 8;
  localparam int CSR = 2;
  localparam int CHR = 3;
  localparam int RASC = 5;
  localparam int RP = 4;
  localparam int URG = 3;
  localparam int LOST = 6;
  localparam int PAUSE_CYC = CLK_KHZ * PAUSE_US / 1000;
  localparam int INTERVAL = CLK_KHZ * RET_MS / ROWS;

  // wake-up table: {grant delay in cycles, expected init_done after the cycle}
  localparam int VEC_N = 8;
  localparam int VEC [VEC_N][2] = '{
    '{0, 0}, '{1, 0}, '{3, 0}, '{0, 0},
    '{2, 0}, '{5, 0}, '{1, 0}, '{0, 1}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       man_grant = 1'b0;
  logic       auto_grant = 1'b0;
  logic       bus_grant;
  logic       ref_req, ref_urgent, own_bus, ras_n, init_done;
  logic [1:0] cas_n;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  assign bus_grant = man_grant | (auto_grant & ref_req);

  dram_refresh_sched #(
    .CLK_KHZ(CLK_KHZ), .PAUSE_US(PAUSE_US), .RETENTION_MS(RET_MS), .ROWS(ROWS),
    .WAKE_CYCLES(WAKE), .CAS_LINES(2), .CSR_CYC(CSR), .CHR_CYC(CHR),
    .RAS_CYC(RASC), .RP_CYC(RP), .URGENT_LEVEL(URG), .LOST_LEVEL(LOST)
  ) u_dram_refresh_sched (
    .clk(clk), .rst(rst), .bus_grant(bus_grant), .ref_req(ref_req),
    .ref_urgent(ref_urgent), .own_bus(own_bus), .ras_n(ras_n),
    .cas_n(cas_n), .init_done(init_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // strobe-shape monitor (R4) and idle-quiet monitor (R5)
  int phase = 0, m_csr = 0, m_chr = 0, m_ras = 0, m_pre = 0;
  int cycles_seen = 0, quiet_bad = 0, split_bad = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (cas_n[0] != cas_n[1]) split_bad++;
      if (!own_bus) begin
        if (!ras_n || cas_n != 2'b11) quiet_bad++;
        if (phase != 0) begin
          chk(m_csr == CSR, "R4 column-before-row setup", m_csr, CSR);
          chk(m_chr == CHR, "R4 column hold after row", m_chr, CHR);
          chk(m_ras == RASC, "R4 row active width", m_ras, RASC);
          chk(m_pre == RP, "R4 precharge before release", m_pre, RP);
          cycles_seen++;
          phase = 0;
        end
      end else begin
        if (phase == 0) begin
          phase = 1; m_csr = 0; m_chr = 0; m_ras = 0; m_pre = 0;
        end
        if (ras_n && phase == 1) begin
          if (cas_n == 2'b00) m_csr++;
        end else if (!ras_n) begin
          phase = 2; m_ras++;
          if (cas_n == 2'b00) m_chr++;
        end else begin
          phase = 3; m_pre++;
        end
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1: actual hung expected completion");
    summary();
  end

  task automatic wait_idle();
    int t = 0;
    while ((own_bus || ref_req) && t < 400) begin @(negedge clk); t++; end
  endtask

  initial begin
    int t;
    int cs0;
    int t_req;
    int gap;
    int maxgap;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ras_n == 1'b1 && cas_n == 2'b11, "R1 strobes idle", {ras_n, cas_n}, 7);
    chk(!own_bus && !ref_req && !ref_urgent && !init_done, "R1 flags low",
        {own_bus, ref_req, ref_urgent, init_done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!ref_req && !own_bus && !init_done, "R1 first cycle after reset",
        {ref_req, own_bus, init_done}, 0);

    // R2: pause length
    t = 1;
    while (!ref_req && t < 1000) begin @(negedge clk); t++; end
    chk(t >= PAUSE_CYC && t <= PAUSE_CYC + 2, "R2 pause before request", t, PAUSE_CYC);

    // R3/R5: wake-up burst driven from the table
    for (int i = 0; i < VEC_N; i++) begin
      t = 0;
      while (!ref_req && t < 200) begin @(negedge clk); t++; end
      chk(ref_req, "R5 request raised", ref_req, 1);
      for (int d = 0; d < VEC[i][0]; d++) begin
        @(negedge clk);
        chk(ref_req && !own_bus, "R5 waits for grant", {ref_req, own_bus}, 2);
      end
      man_grant = 1'b1;
      t = 0;
      while (!own_bus && t < 50) begin @(negedge clk); t++; end
      while (own_bus && t < 100) begin
        @(negedge clk); t++;
        if (own_bus) chk(ref_req, "R5 request held while owned", ref_req, 1);
      end
      man_grant = 1'b0;
      @(negedge clk); @(negedge clk);
      chk(init_done == VEC[i][1], "R3 init after wake cycle", init_done, VEC[i][1]);
    end
    chk(cycles_seen == WAKE, "R3 wake cycle count", cycles_seen, WAKE);

    // R6: steady distributed refresh
    auto_grant = 1'b1;
    cs0 = cycles_seen;
    repeat (4 * INTERVAL) @(negedge clk);
    chk(cycles_seen - cs0 >= 3 && cycles_seen - cs0 <= 5, "R6 refresh rate",
        cycles_seen - cs0, 4);
    chk(!ref_urgent, "R7 no urgency when served", ref_urgent, 0);

    // R7: backlog builds while grant is withheld
    wait_idle();
    auto_grant = 1'b0;
    t = 0;
    while (!ref_req && t < 200) begin @(negedge clk); t++; end
    t_req = 0;
    while (!ref_urgent && t_req < 400) begin
      @(negedge clk); t_req++;
      if (own_bus) chk(0, "R5 bus taken without grant", 1, 0);
    end
    chk(t_req >= (URG - 1) * INTERVAL - 2 && t_req <= (URG - 1) * INTERVAL + 2,
        "R7 urgency at threshold", t_req, (URG - 1) * INTERVAL - 1);

    // R9/R7: drain back to back
    auto_grant = 1'b1;
    t = 0; gap = 0; maxgap = 0;
    while (ref_urgent && t < 200) begin
      @(negedge clk); t++;
      if (!own_bus) gap++; else gap = 0;
      if (gap > maxgap) maxgap = gap;
    end
    chk(!ref_urgent, "R7 urgency drops after serving", ref_urgent, 0);
    chk(maxgap <= 4, "R9 back-to-back gap", maxgap, 4);
    chk(init_done, "R8 no restart on moderate backlog", init_done, 1);

    // R8: backlog reaches loss level
    wait_idle();
    auto_grant = 1'b0;
    t = 0;
    while (init_done && t < LOST * INTERVAL + 200) begin @(negedge clk); t++; end
    chk(!init_done, "R8 init withdrawn", init_done, 0);
    chk(!ref_urgent, "R8 backlog cleared", ref_urgent, 0);
    chk(ref_req, "R8 request kept", ref_req, 1);
    cs0 = cycles_seen;
    auto_grant = 1'b1;
    t = 0;
    while (!init_done && t < 1000) begin @(negedge clk); t++; end
    chk(cycles_seen - cs0 == WAKE, "R8 wake burst rerun", cycles_seen - cs0, WAKE);

    // R4/R5 aggregate monitors
    chk(quiet_bad == 0, "R5 strobes quiet while unowned", quiet_bad, 0);
    chk(split_bad == 0, "R4 column lines together", split_bad, 0);

    // R1: reset in mid-run
    wait_idle();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(!init_done && !ref_req && !own_bus && !ref_urgent && ras_n && cas_n == 2'b11,
        "R1 reset mid-run", {init_done, ref_req, own_bus}, 0);
    summary();
  end
endmodule